// File: doc/BRIEF.md
# Three-Wire Strobe-Latched Control Register Bank

This block turns a slow three-wire serial port into a set of control codes for a two-channel actuator driver. A host shifts a 16-bit frame in on the serial data line, one bit per rising edge of the serial clock. Each frame carries a 4-bit register address and then 12 data bits. When the host raises the strobe, the frame is written into the register it addresses. The block drives the codes out as parallel outputs:

- two PWM duty words
- two hall-bias DAC codes and two offset DAC codes
- gain and offset-ratio selectors for both amplifiers
- amplifier enables
- a PWM resolution select
- per-channel edge-shift counts
- a clock-source select

All three serial pins and the active-low standby pin are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. The serial clock must therefore stay well below the system clock. Pulling standby low clears the whole bank and blocks writes until standby is released.

Top module: `strobe_cfg_regs`

## Requirements
- R1: Frames are sent least significant bit first, the address before the data: the first four bits are address bits A0..A3 (A0 is the address LSB), and the next twelve are D0..D11. D0 lands in bit 0 of the target register.
- R2: A frame is written only if exactly 16 bits were shifted in since the last strobe fall. A frame with fewer or more bits is dropped when the strobe rises, and no output changes.
- R3: Serial clock rising edges that arrive while the strobe is high shift nothing. The bit counter restarts on every strobe fall, so the next frame is received intact.
- R4: Address 0 writes the 12-bit channel-1 duty and address 1 writes the 12-bit channel-2 duty, both from D11..D0.
- R5: Addresses 4 and 5 write the channel-1 and channel-2 bias codes. Addresses 2 and 3 write the channel-1 and channel-2 offset codes. Each of these takes 8 bits from D7..D0, and D11..D8 are ignored.
- R6: Addresses 8 and 9 write the 4-bit gain codes of channels 1 and 2. Addresses 10 and 11 write the 4-bit offset-ratio codes of channels 1 and 2. Each takes D3..D0.
- R7: Address 12 writes the amplifier enables: D0 controls amplifier 1 and D1 controls amplifier 2.
- R8: Address 13 writes the PWM resolution from D1:D0 (00 = 10-bit, 01 = 11-bit, 10 = 12-bit). The code 11 leaves the previous value in place. After reset the value is 00.
- R9: Addresses 6 and 7 write the 4-bit edge-shift counts of channels 1 and 2 from D3..D0.
- R10: Address 15 writes the clock select from D0 (0 = external, 1 = internal), and the reset value is external. A frame to address 14 changes nothing.
- R11: While the active-high synchronous reset is high, or while standby_n is low, every output is zero. Frames that complete while standby_n is low are not written.
- R12: A strobe rise or a standby fall at the pin reaches the outputs on the third rising system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Asynchronous active-low standby; clears the bank |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_stb | input | 1 | Strobe; a rising edge commits the frame |
| duty_ch1 | output | 12 | Channel-1 PWM duty |
| duty_ch2 | output | 12 | Channel-2 PWM duty |
| bias_ch1 | output | 8 | Channel-1 bias DAC code |
| bias_ch2 | output | 8 | Channel-2 bias DAC code |
| ofs_ch1 | output | 8 | Channel-1 offset DAC code |
| ofs_ch2 | output | 8 | Channel-2 offset DAC code |
| gain_ch1 | output | 4 | Channel-1 amplifier gain code |
| gain_ch2 | output | 4 | Channel-2 amplifier gain code |
| ofsr_ch1 | output | 4 | Channel-1 offset-ratio code |
| ofsr_ch2 | output | 4 | Channel-2 offset-ratio code |
| amp_en | output | 2 | Amplifier enables, bit 0 = amplifier 1 |
| pwm_res | output | 2 | PWM resolution select |
| shift_ch1 | output | 4 | Channel-1 edge-shift count |
| shift_ch2 | output | 4 | Channel-2 edge-shift count |
| clk_int_sel | output | 1 | 1 = internal clock, 0 = external |

## Verification
The bench sends frames that are 15 and 17 bits long. A design that commits on any strobe rise would overwrite a duty register with garbage instead of leaving it alone. It also toggles the serial clock while the strobe is high and then sends a clean frame. A counter that keeps counting during strobe-high would end with a misaligned address and corrupt an unrelated register. Duty values with only the lowest or only the highest bit set expose a reversed bit order. The bench also writes the reserved resolution code, writes the spare address, and sends a frame during standby. Each of these must leave every output unchanged, and a design that mishandles one shows up as a changed output on the next clock.

// File: rtl/strobe_cfg_pkg.sv
package strobe_cfg_pkg;

    parameter int ADDR_W  = 4;
    parameter int DATA_W  = 12;
    parameter int DUTY_W  = 12;
    parameter int DAC_W   = 8;
    parameter int CODE_W  = 4;
    parameter int SHIFT_W = 4;
    parameter int RES_W   = 2;
    parameter int AMP_N   = 2;

    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        A_DUTY1 = 4'd0,  A_DUTY2 = 4'd1,  A_OFS1  = 4'd2,  A_OFS2  = 4'd3,
        A_BIAS1 = 4'd4,  A_BIAS2 = 4'd5,  A_SHFT1 = 4'd6,  A_SHFT2 = 4'd7,
        A_GAIN1 = 4'd8,  A_GAIN2 = 4'd9,  A_OFSR1 = 4'd10, A_OFSR2 = 4'd11,
        A_AMPEN = 4'd12, A_RES   = 4'd13, A_SPARE = 4'd14, A_TEST  = 4'd15
    } reg_addr_e;

    typedef struct packed {
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [DUTY_W-1:0]  duty1;
        logic [DUTY_W-1:0]  duty2;
        logic [DAC_W-1:0]   bias1;
        logic [DAC_W-1:0]   bias2;
        logic [DAC_W-1:0]   ofs1;
        logic [DAC_W-1:0]   ofs2;
        logic [CODE_W-1:0]  gain1;
        logic [CODE_W-1:0]  gain2;
        logic [CODE_W-1:0]  ofsr1;
        logic [CODE_W-1:0]  ofsr2;
        logic [AMP_N-1:0]   amp_en;
        logic [RES_W-1:0]   res;
        logic [SHIFT_W-1:0] shift1;
        logic [SHIFT_W-1:0] shift2;
        logic               clk_int;
    } cfg_bank_t;

    localparam logic [RES_W-1:0] RES_RESERVED = '1;

    // Keep the old resolution when the reserved code is requested.
    function automatic logic [RES_W-1:0] res_pick(input logic [RES_W-1:0] cur,
                                                  input logic [RES_W-1:0] req);
        return (req == RES_RESERVED) ? cur : req;
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= din[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign lvl[i]  = s2;
        assign rise[i] = s2 & ~prev;
        assign fall[i] = ~s2 & prev;
    end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import strobe_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   sclk_rise,
    input  logic   sdat_lvl,
    input  logic   stb_lvl,
    input  logic   stb_rise,
    input  logic   stb_fall,
    output logic   wr_vld,
    output frame_t wr_frame
);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (stb_fall) begin
            cnt <= '0;
        end else if (sclk_rise && !stb_lvl) begin
            sr  <= {sdat_lvl, sr[FRAME_W-1:1]};
            cnt <= (cnt == CNT_W'(CNT_MAX)) ? cnt : cnt + 1'b1;
        end
    end

    assign wr_vld        = stb_rise && !clr && (cnt == CNT_W'(FRAME_W));
    assign wr_frame.addr = reg_addr_e'(sr[ADDR_W-1:0]);
    assign wr_frame.data = sr[FRAME_W-1:ADDR_W];

    AST_HOLD_WHILE_STB: assert property (@(posedge clk) disable iff (rst)
        (stb_lvl && !clr) |=> ($stable(cnt) && $stable(sr)));  // R3
    AST_RESTART_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        (stb_fall && !clr) |=> (cnt == '0));  // R3

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import strobe_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      wr_vld,
    input  frame_t    wr_frame,
    output cfg_bank_t bank
);

    cfg_bank_t nxt;

    always_comb begin
        nxt = bank;
        unique case (wr_frame.addr)
            A_DUTY1: nxt.duty1   = wr_frame.data[DUTY_W-1:0];
            A_DUTY2: nxt.duty2   = wr_frame.data[DUTY_W-1:0];
            A_OFS1:  nxt.ofs1    = wr_frame.data[DAC_W-1:0];
            A_OFS2:  nxt.ofs2    = wr_frame.data[DAC_W-1:0];
            A_BIAS1: nxt.bias1   = wr_frame.data[DAC_W-1:0];
            A_BIAS2: nxt.bias2   = wr_frame.data[DAC_W-1:0];
            A_SHFT1: nxt.shift1  = wr_frame.data[SHIFT_W-1:0];
            A_SHFT2: nxt.shift2  = wr_frame.data[SHIFT_W-1:0];
            A_GAIN1: nxt.gain1   = wr_frame.data[CODE_W-1:0];
            A_GAIN2: nxt.gain2   = wr_frame.data[CODE_W-1:0];
            A_OFSR1: nxt.ofsr1   = wr_frame.data[CODE_W-1:0];
            A_OFSR2: nxt.ofsr2   = wr_frame.data[CODE_W-1:0];
            A_AMPEN: nxt.amp_en  = wr_frame.data[AMP_N-1:0];
            A_RES:   nxt.res     = res_pick(bank.res, wr_frame.data[RES_W-1:0]);
            A_SPARE: nxt         = bank;
            A_TEST:  nxt.clk_int = wr_frame.data[0];
            default: nxt         = bank;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) bank <= '0;
        else if (wr_vld) bank <= nxt;
    end

    AST_BANK_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bank != $past(bank)) |-> ($past(wr_vld) || $past(clr)));  // R2
    AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bank == cfg_bank_t'('0)));  // R11
    AST_RES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        bank.res != RES_RESERVED);  // R8

endmodule

// File: rtl/strobe_cfg_regs.sv
module strobe_cfg_regs
    import strobe_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               standby_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_stb,
    output logic [DUTY_W-1:0]  duty_ch1,
    output logic [DUTY_W-1:0]  duty_ch2,
    output logic [DAC_W-1:0]   bias_ch1,
    output logic [DAC_W-1:0]   bias_ch2,
    output logic [DAC_W-1:0]   ofs_ch1,
    output logic [DAC_W-1:0]   ofs_ch2,
    output logic [CODE_W-1:0]  gain_ch1,
    output logic [CODE_W-1:0]  gain_ch2,
    output logic [CODE_W-1:0]  ofsr_ch1,
    output logic [CODE_W-1:0]  ofsr_ch2,
    output logic [AMP_N-1:0]   amp_en,
    output logic [RES_W-1:0]   pwm_res,
    output logic [SHIFT_W-1:0] shift_ch1,
    output logic [SHIFT_W-1:0] shift_ch2,
    output logic               clk_int_sel
);

    localparam int P_SCLK = 0;
    localparam int P_SDAT = 1;
    localparam int P_STB  = 2;
    localparam int P_SBY  = 3;
    localparam int NPIN   = 4;

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic            clr;
    logic            wr_vld;
    frame_t          wr_frame;
    cfg_bank_t       bank;

    sync_edge #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({standby_n, ser_stb, ser_dat, ser_clk}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign clr = ~pin_lvl[P_SBY];

    frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .sclk_rise (pin_rise[P_SCLK]),
        .sdat_lvl  (pin_lvl[P_SDAT]),
        .stb_lvl   (pin_lvl[P_STB]),
        .stb_rise  (pin_rise[P_STB]),
        .stb_fall  (pin_fall[P_STB]),
        .wr_vld    (wr_vld),
        .wr_frame  (wr_frame)
    );

    cfg_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_vld   (wr_vld),
        .wr_frame (wr_frame),
        .bank     (bank)
    );

    assign duty_ch1    = bank.duty1;
    assign duty_ch2    = bank.duty2;
    assign bias_ch1    = bank.bias1;
    assign bias_ch2    = bank.bias2;
    assign ofs_ch1     = bank.ofs1;
    assign ofs_ch2     = bank.ofs2;
    assign gain_ch1    = bank.gain1;
    assign gain_ch2    = bank.gain2;
    assign ofsr_ch1    = bank.ofsr1;
    assign ofsr_ch2    = bank.ofsr2;
    assign amp_en      = bank.amp_en;
    assign pwm_res     = bank.res;
    assign shift_ch1   = bank.shift1;
    assign shift_ch2   = bank.shift2;
    assign clk_int_sel = bank.clk_int;

    AST_NO_COMMIT_IN_STANDBY: assert property (@(posedge clk) disable iff (rst)
        (!standby_n && $past(!standby_n) && $past(!standby_n, 2)) |=> (duty_ch1 == '0 && clk_int_sel == 1'b0));  // R11

endmodule

// File: tb/strobe_cfg_regs_bench.sv
module strobe_cfg_regs_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_n = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;

    logic [11:0] duty_ch1, duty_ch2;
    logic [7:0]  bias_ch1, bias_ch2, ofs_ch1, ofs_ch2;
    logic [3:0]  gain_ch1, gain_ch2, ofsr_ch1, ofsr_ch2, shift_ch1, shift_ch2;
    logic [1:0]  amp_en, pwm_res;
    logic        clk_int_sel;

    always #2.5 clk = ~clk;

    strobe_cfg_regs u_strobe_cfg_regs (
        .clk(clk), .rst(rst), .standby_n(standby_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
        .duty_ch1(duty_ch1), .duty_ch2(duty_ch2),
        .bias_ch1(bias_ch1), .bias_ch2(bias_ch2),
        .ofs_ch1(ofs_ch1), .ofs_ch2(ofs_ch2),
        .gain_ch1(gain_ch1), .gain_ch2(gain_ch2),
        .ofsr_ch1(ofsr_ch1), .ofsr_ch2(ofsr_ch2),
        .amp_en(amp_en), .pwm_res(pwm_res),
        .shift_ch1(shift_ch1), .shift_ch2(shift_ch2),
        .clk_int_sel(clk_int_sel)
    );

    // Behavioural model: one integer per register, indexed by address.
    int    m [16];
    int    vectors = 0, miscompares = 0;
    bit    comparing = 0, finished = 0;
    string cur_req = "R11";
    bit    sby_low = 0;

    function automatic void model_clear();
        for (int i = 0; i < 16; i++) m[i] = 0;
    endfunction

    function automatic void model_write(int a, int d);
        case (a)
            0, 1:           m[a] = d & 12'hFFF;
            2, 3, 4, 5:     m[a] = d & 8'hFF;
            6, 7, 8, 9, 10, 11: m[a] = d & 4'hF;
            12:             m[a] = d & 2'h3;
            13:             if ((d & 3) != 3) m[a] = d & 3;
            15:             m[a] = d & 1;
            default: ;
        endcase
    endfunction

    function automatic logic [127:0] expect_vec();
        return {m[0][11:0], m[1][11:0], m[4][7:0], m[5][7:0], m[2][7:0], m[3][7:0],
                m[8][3:0], m[9][3:0], m[10][3:0], m[11][3:0], m[12][1:0], m[13][1:0],
                m[6][3:0], m[7][3:0], m[15][0]};
    endfunction

    function automatic logic [127:0] actual_vec();
        return {duty_ch1, duty_ch2, bias_ch1, bias_ch2, ofs_ch1, ofs_ch2,
                gain_ch1, gain_ch2, ofsr_ch1, ofsr_ch2, amp_en, pwm_res,
                shift_ch1, shift_ch2, clk_int_sel};
    endfunction

    always @(negedge clk) begin
        if (comparing && !finished) begin
            vectors++;
            if (actual_vec() !== expect_vec()) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h at %0t", cur_req,
                         actual_vec(), expect_vec(), $time);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Shifts nb bits (address LSB first, then data LSB first), strobes,
    // and updates the model on the third system edge after the strobe rise.
    task automatic send(int a, int d, int nb = 16, int noise = 0);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            ser_dat = (i < 4) ? a[i] : ((i < 16) ? d[i-4] : 1'b1);
            wait_cyc(2);
            ser_clk = 1'b1;
            wait_cyc(2);
            ser_clk = 1'b0;
            wait_cyc(1);
        end
        @(negedge clk);
        ser_stb = 1'b1;
        repeat (3) @(posedge clk);
        if (nb == 16 && !sby_low) model_write(a, d);
        for (int j = 0; j < noise; j++) begin
            wait_cyc(2); ser_clk = 1'b1; ser_dat = j[0];
            wait_cyc(2); ser_clk = 1'b0;
        end
        wait_cyc(4);
        ser_stb = 1'b0;
        wait_cyc(5);
    endtask

    initial begin
        model_clear();
        wait_cyc(4);
        comparing = 1;            // reset state
        cur_req = "R11";
        wait_cyc(2);
        @(negedge clk) rst = 1'b0;
        wait_cyc(8);

        cur_req = "R1";  send(0, 12'h001); send(0, 12'h800); send(1, 12'h001);
        cur_req = "R4";  send(0, 12'hABC); send(1, 12'h5A3);
        cur_req = "R5";  send(4, 12'hFA5); send(5, 12'h13C); send(2, 12'hE81); send(3, 12'h7FF);
        cur_req = "R6";  send(8, 12'hFF6); send(9, 12'h00F); send(10, 12'h3A9); send(11, 12'h001);
        cur_req = "R7";  send(12, 12'hFFD); send(12, 12'h002);
        cur_req = "R8";  send(13, 12'h001); send(13, 12'h003); send(13, 12'hFF2);
        cur_req = "R9";  send(6, 12'hFF7); send(7, 12'h0A8);
        cur_req = "R10"; send(15, 12'h001); send(14, 12'hFFF); send(15, 12'hFFE); send(15, 12'h001);
        cur_req = "R2";  send(0, 12'hFFF, 15); send(1, 12'h000, 17); send(9, 12'h000, 4);
        cur_req = "R3";  send(4, 12'h0C3, 16, 7); send(5, 12'h09E, 16, 3); send(0, 12'h777);
        cur_req = "R12"; send(2, 12'h0AA); send(3, 12'h055);

        cur_req = "R11";
        @(negedge clk) standby_n = 1'b0;
        repeat (3) @(posedge clk);
        model_clear();
        sby_low = 1;
        send(0, 12'h321);
        send(15, 12'h001);
        @(negedge clk) standby_n = 1'b1;
        repeat (3) @(posedge clk);
        sby_low = 0;
        wait_cyc(4);
        send(1, 12'h456);
        cur_req = "R11";
        @(negedge clk) rst = 1'b1;
        @(posedge clk) model_clear();
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(6);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule